// File: doc/BRIEF.md
# Duplex LCD Segment Driver

This block drives a two-common LCD panel with 1/2 duty and 1/2 bias. It has 23 segment pins. A display map holds one cell for each pairing of a segment pin and a common, which makes 46 cells. The map is written over a simple command port in one of two ways. A raw write loads one whole common's column of cells from the data word. A decode write turns a 4-bit hex value into a seven-segment glyph and stores it in one of six seven-cell digit slots.

A divider counts down the master clock, 4.5 MHz by default, and splits each frame into four equal quarters. This gives a 100 Hz frame. In the first two quarters common 0 is selected and in the last two common 1 is selected. Within each pair, the first quarter is the positive half and the second is the negative half, so the panel sees no DC. Each common leaves the block as a 2-bit code for three levels (low, mid, high), which an external bias ladder turns into voltages. Segment pins are plain logic levels.

Reset clears the map, so every segment shows blank while the commons keep scanning. Standby forces every output low. Any pin can be switched to static general-purpose use.

Top module: `lcd_duplex_top`

## Requirements
- R1: Each common is coded on 2 bits as 00 for low, 01 for mid and 10 for high. The code 11 never appears. Outside standby, exactly one common is not at mid. The selected common is high in the positive half and low in the negative half.
- R2: The quarters run in this order: common 0 positive, common 0 negative, common 1 positive, common 1 negative. Each quarter lasts CLK_HZ/(4*FRAME_HZ) clock cycles, which is 11250 cycles at the defaults.
- R3: In non-GP mode, a pin whose cell for the selected common is 1 (lit) drives the level opposite to that common: 0 in the positive half, 1 in the negative half. An unlit pin drives the same level as the selected common.
- R4: The cell of pin i for common c has flat index 2*i+c. A raw write (wrDecode=0) stores wrData[i] into the cell of pin i for common wrSel[0], for every pin.
- R5: A decode write (wrDecode=1) converts wrData[3:0] into the glyph bits a..g (bit 0 = a) and stores bit k at flat cell 7*wrSel+k. The glyphs for values 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71, in hex.
- R6: A decode write with wrSel of 6 or 7 leaves the map unchanged.
- R7: While reset is held, every output is 0. Once reset is released, the map is all zero, so every segment is unlit and the commons scan as in R1 and R2.
- R8: The clock edge that samples standby high sets all segment and common outputs to 0. The frame restarts from its first quarter: on the first edge after standby falls, common 0 is high and common 1 is mid.
- R9: A pin with gpMode set drives the value of its common-0 cell as a static level, in every quarter.
- R10: An output reflects a map write from the second clock edge after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| standby | input | 1 | Forces all outputs low and holds the frame at its start |
| wrEn | input | 1 | Map write strobe |
| wrDecode | input | 1 | 1 = hex-decode write, 0 = raw write |
| wrSel | input | 3 | Digit slot (decode) or common plane in bit 0 (raw) |
| wrData | input | 23 | Raw cell data, or hex value in bits 3:0 |
| gpMode | input | 23 | Per-pin static general-purpose select |
| segOut | output | 23 | Segment pin levels |
| comOut | output | 4 | Common level codes, common 0 in bits 1:0 |

## Verification
The hardest condition to reach from the ports is a mismatch between a segment pin and the quarter it is sampled in, because the phase is not visible directly. The bench therefore works out the selected common and the polarity on every cycle from the common codes. From these and its own model of the map it predicts every segment pin, and it counts how many cycles each quarter lasts over a whole frame. All sixteen hex glyphs are then driven through slots 0 to 5 on top of a raw background. This shows how the glyph cells interleave across the pins of neighbouring digit slots. The standby exit is checked on its very first cycle to confirm that the frame restarts in the right quarter.

// File: rtl/lcd_duplex_pkg.sv
package lcd_duplex_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_MID  = 2'b01,
    LVL_HIGH = 2'b10
  } lvl_e;

  typedef struct packed {
    logic comSel;
    logic polarity;
    logic hush;
  } strobe_t;

  function automatic logic [6:0] hexToSeg(input logic [3:0] v);
    logic [6:0] g;
    case (v)
      4'h0: g = 7'h3F;  4'h1: g = 7'h06;  4'h2: g = 7'h5B;  4'h3: g = 7'h4F;
      4'h4: g = 7'h66;  4'h5: g = 7'h6D;  4'h6: g = 7'h7D;  4'h7: g = 7'h07;
      4'h8: g = 7'h7F;  4'h9: g = 7'h6F;  4'hA: g = 7'h77;  4'hB: g = 7'h7C;
      4'hC: g = 7'h39;  4'hD: g = 7'h5E;  4'hE: g = 7'h79;  default: g = 7'h71;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/lcd_duplex_ctl.sv
module lcd_duplex_ctl
  import lcd_duplex_pkg::*;
#(
  parameter int CLK_HZ   = 4500000,
  parameter int FRAME_HZ = 100
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    standby,
  output strobe_t stb
);
  localparam int QUARTER = CLK_HZ / (FRAME_HZ * 4);
  localparam int CW      = (QUARTER > 2) ? $clog2(QUARTER) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUARTER - 1);

  logic [CW-1:0] divCnt;
  logic [1:0]    phase;

  always_ff @(posedge clk) begin
    if (!rstN || standby) begin
      divCnt <= '0;
      phase  <= '0;
    end else if (divCnt == LAST) begin
      divCnt <= '0;
      phase  <= phase + 2'd1;
    end else begin
      divCnt <= divCnt + CW'(1);
    end
  end

  always_comb begin
    stb.comSel   = phase[1];
    stb.polarity = phase[0];
    stb.hush     = standby;
  end

  // R2
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!standby && divCnt != LAST) |=> $stable(phase));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!standby && divCnt == LAST) |=> phase == $past(phase) + 2'd1);

endmodule

// File: rtl/lcd_duplex_dp.sv
module lcd_duplex_dp
  import lcd_duplex_pkg::*;
#(
  parameter int SEGS  = 23,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic             wrEn,
  input  logic             wrDecode,
  input  logic [SEL_W-1:0] wrSel,
  input  logic [SEGS-1:0]  wrData,
  input  logic [SEGS-1:0]  gpMode,
  output logic [SEGS-1:0]  segOut,
  output logic [3:0]       comOut
);
  localparam int CELLS   = 2 * SEGS;
  localparam int NUM_DIG = CELLS / 7;

  logic [CELLS-1:0] dispMap;
  logic [6:0]       glyph;
  logic [SEGS-1:0]  segNext;
  logic [3:0]       comNext;

  assign glyph = hexToSeg(wrData[3:0]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispMap <= '0;
    end else if (wrEn) begin
      if (wrDecode) begin
        for (int d = 0; d < NUM_DIG; d++)
          if (wrSel == SEL_W'(d)) dispMap[7*d +: 7] <= glyph;
      end else begin
        for (int i = 0; i < SEGS; i++)
          if (wrSel[0]) dispMap[2*i+1] <= wrData[i];
          else          dispMap[2*i]   <= wrData[i];
      end
    end
  end

  for (genvar i = 0; i < SEGS; i++) begin : g_pin
    logic lit;
    assign lit = stb.comSel ? dispMap[2*i+1] : dispMap[2*i];
    always_comb begin
      if (stb.hush)       segNext[i] = 1'b0;
      else if (gpMode[i]) segNext[i] = dispMap[2*i];
      else                segNext[i] = stb.polarity ? lit : ~lit;
    end

    // R9
    gp_static_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && !$past(stb.hush) && $past(gpMode[i])) |-> segOut[i] == $past(dispMap[2*i]));
  end

  for (genvar c = 0; c < 2; c++) begin : g_com
    always_comb begin
      if (stb.hush)                comNext[2*c +: 2] = LVL_LOW;
      else if (stb.comSel == c[0]) comNext[2*c +: 2] = stb.polarity ? LVL_LOW : LVL_HIGH;
      else                         comNext[2*c +: 2] = LVL_MID;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segOut <= '0;
      comOut <= '0;
    end else begin
      segOut <= segNext;
      comOut <= comNext;
    end
  end

  // R8
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.hush |=> (segOut == '0 && comOut == '0));

  // R1
  one_com_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(stb.hush)) |->
      (((comOut[1:0] == LVL_MID) != (comOut[3:2] == LVL_MID)) &&
       comOut[1:0] != 2'b11 && comOut[3:2] != 2'b11));

  // R6
  ignore_digit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrDecode && int'(wrSel) >= NUM_DIG) |=> $stable(dispMap));

endmodule

// File: rtl/lcd_duplex_top.sv
module lcd_duplex_top
  import lcd_duplex_pkg::*;
#(
  parameter int SEGS     = 23,
  parameter int CLK_HZ   = 4500000,
  parameter int FRAME_HZ = 100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            standby,
  input  logic            wrEn,
  input  logic            wrDecode,
  input  logic [2:0]      wrSel,
  input  logic [SEGS-1:0] wrData,
  input  logic [SEGS-1:0] gpMode,
  output logic [SEGS-1:0] segOut,
  output logic [3:0]      comOut
);
  strobe_t stb;

  lcd_duplex_ctl #(.CLK_HZ(CLK_HZ), .FRAME_HZ(FRAME_HZ)) u_ctl (
    .clk(clk), .rstN(rstN), .standby(standby), .stb(stb)
  );

  lcd_duplex_dp #(.SEGS(SEGS), .SEL_W(3)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrEn(wrEn), .wrDecode(wrDecode),
    .wrSel(wrSel), .wrData(wrData), .gpMode(gpMode),
    .segOut(segOut), .comOut(comOut)
  );

endmodule

// File: tb/lcd_duplex_top_bench.sv
module lcd_duplex_top_bench;
  localparam int SEGS = 23;
  localparam int QUARTER = 4;   // CLK_HZ 1600 / (4 * 100)

  logic clk = 1'b0, rstN = 1'b0, standby = 1'b0;
  logic wrEn = 1'b0, wrDecode = 1'b0;
  logic [2:0] wrSel = '0;
  logic [SEGS-1:0] wrData = '0, gpMode = '0;
  logic [SEGS-1:0] segOut;
  logic [3:0] comOut;

  int nChk = 0, nBad = 0;
  logic [2*SEGS-1:0] mdl = '0;

  // R5 glyph table: {value, expected a..g pattern}
  localparam logic [10:0] GLYPHS [16] = '{
    {4'h0, 7'h3F}, {4'h1, 7'h06}, {4'h2, 7'h5B}, {4'h3, 7'h4F},
    {4'h4, 7'h66}, {4'h5, 7'h6D}, {4'h6, 7'h7D}, {4'h7, 7'h07},
    {4'h8, 7'h7F}, {4'h9, 7'h6F}, {4'hA, 7'h77}, {4'hB, 7'h7C},
    {4'hC, 7'h39}, {4'hD, 7'h5E}, {4'hE, 7'h79}, {4'hF, 7'h71}
  };

  lcd_duplex_top #(.SEGS(SEGS), .CLK_HZ(1600), .FRAME_HZ(100)) u_lcd_duplex_top (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .wrDecode(wrDecode),
    .wrSel(wrSel), .wrData(wrData), .gpMode(gpMode), .segOut(segOut), .comOut(comOut)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic dec, input logic [2:0] sel, input logic [SEGS-1:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrDecode = dec; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // one full frame: infer quarter from commons, predict segments
  task automatic checkFrame(input string tag);
    int cnt [4];
    for (int q = 0; q < 4; q++) cnt[q] = 0;
    for (int s = 0; s < 4 * QUARTER; s++) begin
      logic sel, pol, ok;
      logic [1:0] lv;
      logic [SEGS-1:0] exp;
      @(negedge clk);
      ok = 1'b1; sel = 1'b0; lv = 2'b11;
      if (comOut[1:0] != 2'b01 && comOut[3:2] == 2'b01) begin sel = 1'b0; lv = comOut[1:0]; end
      else if (comOut[3:2] != 2'b01 && comOut[1:0] == 2'b01) begin sel = 1'b1; lv = comOut[3:2]; end
      else ok = 1'b0;
      if (lv != 2'b10 && lv != 2'b00) ok = 1'b0;
      pol = (lv == 2'b00);
      check("R1 common levels", ok, 64'(comOut), 64'h0);
      if (ok) begin
        cnt[{sel, pol}]++;
        for (int i = 0; i < SEGS; i++)
          exp[i] = gpMode[i] ? mdl[2*i] : (pol ? mdl[2*i+sel] : ~mdl[2*i+sel]);
        check({tag, " R3 segments"}, segOut == exp, 64'(segOut), 64'(exp));
      end
    end
    for (int q = 0; q < 4; q++)
      check("R2 quarter length", cnt[q] == QUARTER, 64'(cnt[q]), 64'(QUARTER));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: outputs low under reset
    check("R7 seg in reset", segOut == '0, 64'(segOut), 64'h0);
    check("R7 com in reset", comOut == '0, 64'(comOut), 64'h0);
    rstN = 1'b1;
    checkFrame("R7 blank after reset");

    // R4 raw writes, R10 visibility from second edge
    wr(1'b0, 3'd0, 23'h5A5A5A);
    for (int i = 0; i < SEGS; i++) mdl[2*i] = 1'(23'h5A5A5A >> i);
    checkFrame("R4 raw com0 R10");
    wr(1'b0, 3'd1, 23'h0F0F0F);
    for (int i = 0; i < SEGS; i++) mdl[2*i+1] = 1'(23'h0F0F0F >> i);
    checkFrame("R4 raw com1");

    // R5 table walk over all glyphs
    for (int v = 0; v < 16; v++) begin
      int d;
      d = v % 6;
      wr(1'b1, 3'(d), {19'h0, GLYPHS[v][10:7]});
      mdl[7*d +: 7] = GLYPHS[v][6:0];
      checkFrame($sformatf("R5 glyph %0h", v));
    end

    // R6 out-of-range slots ignored
    wr(1'b1, 3'd6, 23'h8);
    wr(1'b1, 3'd7, 23'h1);
    checkFrame("R6 slot 6/7 ignored");

    // R9 general-purpose pins
    gpMode = 23'h700F0F;
    checkFrame("R9 gp mode");
    gpMode = '0;

    // R8 standby
    @(negedge clk); standby = 1'b1;
    @(negedge clk);
    check("R8 seg standby", segOut == '0, 64'(segOut), 64'h0);
    check("R8 com standby", comOut == '0, 64'(comOut), 64'h0);
    repeat (5) @(negedge clk);
    check("R8 seg held", segOut == '0, 64'(segOut), 64'h0);
    standby = 1'b0;
    @(negedge clk);
    check("R8 restart quarter", comOut == 4'b0110, 64'(comOut), 64'h6);
    checkFrame("R8 after standby");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule